// File: doc/BRIEF.md
# Region Protection and Translation Unit

This unit gives a processor core without a paged memory manager a coarse form of address translation and access protection. The 32-bit virtual space is cut into eight equal 512 MB regions, chosen by the three most significant address bits. For every region the unit keeps a physical base and a 4-bit attribute code. The code is decoded into read, write and execute rights plus a cache policy, and the request (load, store or fetch) is checked against those rights. Two independent tables are held: one serves instruction fetches, the other serves loads and stores.

A mode input switches to a cache-attribute mode. In this mode the tables are not consulted, the address passes through untranslated, and the attribute comes from a 32-bit cache-attribute word supplied at the port, one nibble per region. The decode in that mode matches the region decode except that code 5 grants nothing.

Translation and checking are purely combinational, so the response is valid in the same cycle as the request. Table entries are loaded through a small write port and are seen by requests from the next clock cycle on.

Top module: `region_xlate_unit`

## Requirements
- R1: In region mode the region number is `req_vaddr[31:29]`, and `rsp_paddr` is the selected entry's 3-bit base placed in bits [31:29] with `req_vaddr[28:0]` carried through unchanged.
- R2: After reset every entry of both tables has base equal to its own region number (identity map) and attribute 2.
- R3: Attribute decode in region mode, rights given as read/write/execute: code 0 read+write, write-through; code 1 read+write+execute, write-through; code 2 read+write+execute, uncached; codes 4 and 5 read+write+execute, write-back; code 3 execute only, write-back; code 14 read+write, isolate; every other code no rights and cache policy none.
- R4: When `mode_cattr` is 1, `rsp_paddr` equals `req_vaddr`, and the attribute is `cacheattr[4*r+3:4*r]` for region r, decoded as in R3 except that code 5 gives no rights and cache policy none.
- R5: `req_kind` encodes 0 load, 1 store, 2 fetch; a load needs read, a store needs write, a fetch needs execute. On a denial `rsp_fault` is 1 and `rsp_cause` is 1 (load), 2 (store) or 3 (fetch); when granted `rsp_fault` is 0 and `rsp_cause` is 0.
- R6: A fetch reads the instruction table and every other kind reads the data table; `wr_side` selects the table written, 0 data and 1 instruction.
- R7: A write (`wr_en` high at a rising edge) updates only the addressed entry of the addressed table; requests in the same cycle still see the old entry, requests from the next cycle on see the new one.
- R8: `req_kind` code 3 is reserved: it uses the data table, is never granted, and reports cause 2.
- R9: `rsp_cache` encodes the cache policy as 0 none, 1 uncached, 2 write-through, 3 write-back, 4 isolate.
- R10: `rsp_valid` equals `req_valid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| mode_cattr | input | 1 | 1 selects cache-attribute mode, 0 region mode |
| cacheattr | input | 32 | Cache-attribute word, 4 bits per region |
| wr_en | input | 1 | Table entry write strobe |
| wr_side | input | 1 | Table written: 0 data, 1 instruction |
| wr_index | input | 3 | Region number written |
| wr_base | input | 3 | New physical base (address bits [31:29]) |
| wr_attr | input | 4 | New attribute code |
| rsp_valid | output | 1 | Response valid, follows req_valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_read | output | 1 | Read right granted by the attribute |
| rsp_write | output | 1 | Write right granted by the attribute |
| rsp_exec | output | 1 | Execute right granted by the attribute |
| rsp_cache | output | 3 | Cache policy code |
| rsp_fault | output | 1 | Access denied |
| rsp_cause | output | 2 | Fault cause: 0 none, 1 load, 2 store, 3 fetch |

## Verification
On every cycle the assertions check that the offset bits survive translation in region mode and the whole address in cache-attribute mode, that a fault always carries a cause and a grant never does, that the reserved kind always faults, that a policy of none comes with no rights, and that table entries change only through a write and take its value on the following cycle. The exact attribute decode for all sixteen codes in both modes, the identity map after reset, the split between instruction and data tables, and the same-cycle invisibility of a write can only be shown by the bench's directed scenarios, which compare against values derived from the requirements.

// File: rtl/rxu_pkg.sv
// Shared types of the region protection and translation unit.
// Assumes: encodings below are the ones documented at the top-level ports.
package rxu_pkg;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        CM_NONE    = 3'd0,
        CM_BYPASS  = 3'd1,
        CM_WT      = 3'd2,
        CM_WB      = 3'd3,
        CM_ISOLATE = 3'd4
    } cmode_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_LOAD  = 2'd1,
        CAUSE_STORE = 2'd2,
        CAUSE_FETCH = 2'd3
    } cause_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

endpackage

// File: rtl/rxu_attr_decode.sv
// Attribute decoder: turns an attribute code into access rights and a
// cache policy. Assumes: in cache-attribute mode code 5 is undefined,
// in region mode it equals code 4. Purely combinational.
module rxu_attr_decode
    import rxu_pkg::*;
#(
    parameter int ATTR_W = 4
) (
    input  logic [ATTR_W-1:0] attr,
    input  logic              cattr_mode,
    output rights_t           rights,
    output cmode_e            cmode
);

    // Sparse decode table; unlisted codes grant nothing.
    always_comb begin
        rights = '0;
        cmode  = CM_NONE;
        case (attr)
            ATTR_W'(0): begin rights = '{1'b1, 1'b1, 1'b0}; cmode = CM_WT; end
            ATTR_W'(1): begin rights = '{1'b1, 1'b1, 1'b1}; cmode = CM_WT; end
            ATTR_W'(2): begin rights = '{1'b1, 1'b1, 1'b1}; cmode = CM_BYPASS; end
            ATTR_W'(3): begin rights = '{1'b0, 1'b0, 1'b1}; cmode = CM_WB; end
            ATTR_W'(4): begin rights = '{1'b1, 1'b1, 1'b1}; cmode = CM_WB; end
            ATTR_W'(5): begin
                if (!cattr_mode) begin
                    rights = '{1'b1, 1'b1, 1'b1};
                    cmode  = CM_WB;
                end
            end
            ATTR_W'(14): begin rights = '{1'b1, 1'b1, 1'b0}; cmode = CM_ISOLATE; end
            default: ;
        endcase
    end

endmodule

// File: rtl/rxu_access_check.sv
// Rights checker: compares the request kind with the granted rights and
// produces the fault flag and cause. Assumes: the reserved kind is never
// granted and is reported as a store denial. Purely combinational.
module rxu_access_check
    import rxu_pkg::*;
(
    input  kind_e   kind,
    input  rights_t rights,
    output logic    fault,
    output cause_e  cause
);

    // Pick the right each kind needs and name the denial.
    always_comb begin
        fault = 1'b1;
        cause = CAUSE_STORE;
        case (kind)
            KIND_LOAD:  begin fault = !rights.rd; cause = CAUSE_LOAD;  end
            KIND_STORE: begin fault = !rights.wr; cause = CAUSE_STORE; end
            KIND_FETCH: begin fault = !rights.ex; cause = CAUSE_FETCH; end
            default:    begin fault = 1'b1;       cause = CAUSE_STORE; end
        endcase
        if (!fault) cause = CAUSE_NONE;
    end

endmodule

// File: rtl/rxu_region_table.sv
// One region table: a physical base and an attribute per region, loaded
// through a single write port, read combinationally by region number.
// Assumes: writes land at the clock edge; reset gives an identity map.
module rxu_region_table #(
    parameter int REGION_BITS = 3,
    parameter int ATTR_W      = 4,
    parameter int RESET_ATTR  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [REGION_BITS-1:0] wr_index,
    input  logic [REGION_BITS-1:0] wr_base,
    input  logic [ATTR_W-1:0]      wr_attr,
    input  logic [REGION_BITS-1:0] rd_index,
    output logic [REGION_BITS-1:0] rd_base,
    output logic [ATTR_W-1:0]      rd_attr
);

    localparam int NREG = 1 << REGION_BITS;

    logic [NREG-1:0][REGION_BITS-1:0] base_q;
    logic [NREG-1:0][ATTR_W-1:0]      attr_q;

    // Entry storage: identity map on reset, single-entry update on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                base_q[i] <= REGION_BITS'(i);
                attr_q[i] <= ATTR_W'(RESET_ATTR);
            end
        end else if (wr_en) begin
            base_q[wr_index] <= wr_base;
            attr_q[wr_index] <= wr_attr;
        end
    end

    // Combinational read of the addressed entry.
    always_comb begin
        rd_base = base_q[rd_index];
        rd_attr = attr_q[rd_index];
    end

    // R7
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (base_q[$past(wr_index)] == $past(wr_base)) &&
                  (attr_q[$past(wr_index)] == $past(wr_attr)));

    // R7
    no_wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(base_q) && $stable(attr_q));

endmodule

// File: rtl/region_xlate_unit.sv
// Region protection and translation unit (top). Selects the instruction or
// data table by request kind, forms the physical address, decodes the
// attribute from the table or from the cache-attribute word, and checks
// the request. Assumes: ADDR_W >= REGION_BITS and the cache-attribute word
// holds one ATTR_W field per region. Outputs are combinational.
module region_xlate_unit
    import rxu_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int REGION_BITS = 3,
    parameter int ATTR_W      = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [ADDR_W-1:0]             req_vaddr,
    input  logic [1:0]                    req_kind,
    input  logic                          mode_cattr,
    input  logic [(1<<REGION_BITS)*ATTR_W-1:0] cacheattr,
    input  logic                          wr_en,
    input  logic                          wr_side,
    input  logic [REGION_BITS-1:0]        wr_index,
    input  logic [REGION_BITS-1:0]        wr_base,
    input  logic [ATTR_W-1:0]             wr_attr,
    output logic                          rsp_valid,
    output logic [ADDR_W-1:0]             rsp_paddr,
    output logic                          rsp_read,
    output logic                          rsp_write,
    output logic                          rsp_exec,
    output logic [2:0]                    rsp_cache,
    output logic                          rsp_fault,
    output logic [1:0]                    rsp_cause
);

    localparam int OFF_W  = ADDR_W - REGION_BITS;
    localparam int NSIDES = 2;

    kind_e                  kind;
    logic [REGION_BITS-1:0] region;
    logic                   sel_side;
    logic [REGION_BITS-1:0] side_base [NSIDES];
    logic [ATTR_W-1:0]      side_attr [NSIDES];
    logic [ATTR_W-1:0]      attr_eff;
    rights_t                rights;
    cmode_e                 cmode;
    logic                   fault;
    cause_e                 cause;

    // Request decode: kind, region number and table choice.
    always_comb begin
        kind     = kind_e'(req_kind);
        region   = req_vaddr[ADDR_W-1 -: REGION_BITS];
        sel_side = (kind == KIND_FETCH);
    end

    // Side 0 holds data-side entries, side 1 instruction-side entries.
    for (genvar g = 0; g < NSIDES; g++) begin : g_side
        rxu_region_table #(
            .REGION_BITS (REGION_BITS),
            .ATTR_W      (ATTR_W),
            .RESET_ATTR  (2)
        ) i_table (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && (wr_side == 1'(g))),
            .wr_index (wr_index),
            .wr_base  (wr_base),
            .wr_attr  (wr_attr),
            .rd_index (region),
            .rd_base  (side_base[g]),
            .rd_attr  (side_attr[g])
        );
    end

    // Address and attribute source per mode.
    always_comb begin
        if (mode_cattr) begin
            attr_eff  = cacheattr[region*ATTR_W +: ATTR_W];
            rsp_paddr = req_vaddr;
        end else begin
            attr_eff  = side_attr[sel_side];
            rsp_paddr = {side_base[sel_side], req_vaddr[OFF_W-1:0]};
        end
    end

    rxu_attr_decode #(.ATTR_W(ATTR_W)) i_decode (
        .attr       (attr_eff),
        .cattr_mode (mode_cattr),
        .rights     (rights),
        .cmode      (cmode)
    );

    rxu_access_check i_check (
        .kind   (kind),
        .rights (rights),
        .fault  (fault),
        .cause  (cause)
    );

    // Response drive.
    always_comb begin
        rsp_valid = req_valid;
        rsp_read  = rights.rd;
        rsp_write = rights.wr;
        rsp_exec  = rights.ex;
        rsp_cache = cmode;
        rsp_fault = fault;
        rsp_cause = cause;
    end

    // R1
    offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_cattr |-> rsp_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]);

    // R4
    cattr_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_cattr |-> rsp_paddr == req_vaddr);

    // R5
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault == (rsp_cause != 2'd0));

    // R8
    rsvd_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_kind == 2'd3 |-> rsp_fault && rsp_cause == 2'd2);

    // R3
    none_no_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cache == 3'd0 |-> !(rsp_read || rsp_write || rsp_exec));

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == req_valid);

endmodule

// File: tb/test_region_xlate_unit.sv
module test_region_xlate_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic [1:0]  req_kind;
    logic        mode_cattr;
    logic [31:0] cacheattr;
    logic        wr_en;
    logic        wr_side;
    logic [2:0]  wr_index;
    logic [2:0]  wr_base;
    logic [3:0]  wr_attr;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_read, rsp_write, rsp_exec;
    logic [2:0]  rsp_cache;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    region_xlate_unit i_region_xlate_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .mode_cattr(mode_cattr), .cacheattr(cacheattr),
        .wr_en(wr_en), .wr_side(wr_side), .wr_index(wr_index), .wr_base(wr_base),
        .wr_attr(wr_attr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_read(rsp_read), .rsp_write(rsp_write), .rsp_exec(rsp_exec),
        .rsp_cache(rsp_cache), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // Expected {rd,wr,ex,cache[2:0]} from the R3/R4/R9 decode lists.
    function automatic logic [5:0] exp_dec(input int a, input bit cm);
        case (a)
            0:  return {3'b110, 3'd2};
            1:  return {3'b111, 3'd2};
            2:  return {3'b111, 3'd1};
            3:  return {3'b001, 3'd3};
            4:  return {3'b111, 3'd3};
            5:  return cm ? 6'd0 : {3'b111, 3'd3};
            14: return {3'b110, 3'd4};
            default: return 6'd0;
        endcase
    endfunction

    // Expected {fault,cause} from R5/R8.
    function automatic logic [2:0] exp_chk(input int kind, input logic [5:0] d);
        case (kind)
            0: return d[5] ? 3'b000 : 3'b101;
            1: return d[4] ? 3'b000 : 3'b110;
            2: return d[3] ? 3'b000 : 3'b111;
            default: return 3'b110;
        endcase
    endfunction

    // Drive a request at the falling edge and check all outputs 1 ns later.
    task automatic req(input string tag, input int kind, input logic [31:0] va,
                       input logic [31:0] exp_pa, input logic [5:0] d);
        logic [2:0] fc;
        @(negedge clk);
        req_kind  = 2'(kind);
        req_vaddr = va;
        #1;
        fc = exp_chk(kind, d);
        chk({tag, " paddr"}, rsp_paddr, exp_pa);
        chk({tag, " rights/cache"}, {26'd0, rsp_read, rsp_write, rsp_exec, rsp_cache}, {26'd0, d});
        chk({tag, " fault/cause"}, {29'd0, rsp_fault, rsp_cause}, {29'd0, fc});
    endtask

    task automatic wr_entry(input bit side, input int idx, input int base, input int attr);
        @(negedge clk);
        wr_en = 1'b1; wr_side = side; wr_index = 3'(idx);
        wr_base = 3'(base); wr_attr = 4'(attr);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R2, R1, R10: identity map with attribute 2 in both tables after reset.
    task automatic t_reset_state;
        do_reset();
        for (int r = 0; r < 8; r++) begin
            logic [31:0] va;
            va = {3'(r), 29'h0ABC_123};
            req("R2 data load", 0, va, va, exp_dec(2, 0));
            req("R2 instr fetch", 2, va, va, exp_dec(2, 0));
        end
        @(negedge clk);
        req_valid = 1'b0; #1;
        chk("R10 valid low", {31'd0, rsp_valid}, 32'd0);
        req_valid = 1'b1; #1;
        chk("R10 valid high", {31'd0, rsp_valid}, 32'd1);
    endtask

    // R1: remapped base, offset carried through.
    task automatic t_region_map;
        wr_entry(0, 6, 1, 2);
        req("R1 remap low", 0, 32'hC000_0004, 32'h2000_0004, exp_dec(2, 0));
        req("R1 remap high", 1, 32'hDFFF_FFFC, 32'h3FFF_FFFC, exp_dec(2, 0));
    endtask

    // R3, R5, R9: every code in region mode on both tables.
    task automatic t_decode_all;
        for (int a = 0; a < 16; a++) begin
            wr_entry(0, 3, 3, a);
            wr_entry(1, 3, 3, a);
            req("R3 load", 0, 32'h6000_0100, 32'h6000_0100, exp_dec(a, 0));
            req("R5 store", 1, 32'h6000_0200, 32'h6000_0200, exp_dec(a, 0));
            req("R5 fetch", 2, 32'h6000_0300, 32'h6000_0300, exp_dec(a, 0));
        end
    endtask

    // R4: cache-attribute mode, identity address, nibble per region.
    task automatic t_cattr;
        logic [31:0] pats [2];
        pats[0] = 32'h5E43_210F;
        pats[1] = 32'hCBA9_8765;
        @(negedge clk);
        mode_cattr = 1'b1;
        for (int p = 0; p < 2; p++) begin
            cacheattr = pats[p];
            for (int r = 0; r < 8; r++) begin
                logic [31:0] va;
                va = {3'(r), 29'h1234_5678 >> 3};
                req("R4 cattr load", 0, va, va, exp_dec(int'(pats[p][r*4 +: 4]), 1));
                req("R4 cattr fetch", 2, va, va, exp_dec(int'(pats[p][r*4 +: 4]), 1));
            end
        end
        @(negedge clk);
        mode_cattr = 1'b0;
    endtask

    // R6, R7: tables are separate and a write is seen only from the next cycle.
    task automatic t_sides_timing;
        do_reset();
        @(negedge clk);
        wr_en = 1'b1; wr_side = 1'b0; wr_index = 3'd5; wr_base = 3'd1; wr_attr = 4'd0;
        req_kind = 2'd0; req_vaddr = 32'hA000_0010;
        #1;
        chk("R7 same cycle old base", rsp_paddr, 32'hA000_0010);
        chk("R7 same cycle old attr", {29'd0, rsp_read, rsp_write, rsp_exec}, 32'd7);
        @(posedge clk); #1;
        chk("R7 next cycle new base", rsp_paddr, 32'h2000_0010);
        chk("R7 next cycle new attr", {29'd0, rsp_read, rsp_write, rsp_exec}, 32'd6);
        @(negedge clk);
        wr_en = 1'b0;
        req("R6 fetch uses instr table", 2, 32'hA000_0010, 32'hA000_0010, exp_dec(2, 0));
        req("R6 store uses data table", 1, 32'hA000_0010, 32'h2000_0010, exp_dec(0, 0));
        req("R7 neighbour untouched", 0, 32'h8000_0000, 32'h8000_0000, exp_dec(2, 0));
        wr_entry(1, 5, 7, 3);
        req("R6 instr write fetch", 2, 32'hA000_0020, 32'hE000_0020, exp_dec(3, 0));
        req("R6 instr write no data effect", 0, 32'hA000_0020, 32'h2000_0020, exp_dec(0, 0));
    endtask

    // R8: reserved kind always denied with store cause, uses data table.
    task automatic t_reserved;
        do_reset();
        wr_entry(1, 2, 0, 15);
        req("R8 reserved rwx region", 3, 32'h4000_0000, 32'h4000_0000, exp_dec(2, 0));
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b1; req_vaddr = '0; req_kind = '0;
        mode_cattr = 1'b0; cacheattr = '0; wr_en = 1'b0; wr_side = 1'b0;
        wr_index = '0; wr_base = '0; wr_attr = '0;
        t_reset_state();
        t_region_map();
        t_decode_all();
        t_cattr();
        t_sides_timing();
        t_reserved();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule